// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit with Doubling

This block is a purely combinational arithmetic unit for signed fixed-point datapaths. It takes two signed operands, a first operand `rm_val` and a second operand `rn_val`, together with a 2-bit operation select. It returns one of four results:

- a saturating sum;
- a saturating difference;
- a doubling sum, where the second operand is first doubled with saturation and then added with saturation;
- a doubling difference, built the same way but subtracting.

Results that do not fit the signed range are pinned to the nearest representable limit.

Alongside the result, the unit drives `q_set`, a request to set an external sticky overflow flag. The request is raised whenever any clamping stage acts. In the doubling forms there are two clamping stages, and either one can raise it. The unit never asks for the flag to be cleared. It does not hold the flag or any other condition flag.

The operand width is a parameter, with a default of 32. A second parameter selects how overflow is detected: either from a widened intermediate or from a sign-bit comparison. Both variants give identical results.

Top module: `qarith_unit`

## Requirements
- R1: With `op_sel` = 2'b00, `res_val` equals `rm_val + rn_val`, computed as signed values and clamped to the signed W-bit range.
- R2: With `op_sel` = 2'b01, `res_val` equals `rm_val - rn_val`, computed as signed values and clamped to the signed W-bit range.
- R3: With `op_sel` = 2'b10, `res_val` equals `rm_val + D`, clamped, where D is `2*rn_val` clamped to the signed W-bit range on its own.
- R4: With `op_sel` = 2'b11, `res_val` equals `rm_val - D`, clamped, with D defined as in R3.
- R5: A clamped result is the signed maximum (0 followed by ones, 0x7FFFFFFF at W=32) on positive overflow, and the signed minimum (1 followed by zeros, 0x80000000 at W=32) on negative overflow. Overflow is judged on the exact result, never on a wrapped W-bit value.
- R6: `q_set` is 1 exactly when at least one clamping stage acted. In the doubling operations this includes the case where only the doubling of `rn_val` clamped and the final sum or difference is in range.
- R7: In the plain operations (`op_sel[1]` = 0), `rn_val` is used undoubled, so a value of `rn_val` whose double overflows raises no request when the plain sum or difference fits.
- R8: The outputs are a combinational function of the present inputs only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| rm_val | input | W | First signed operand |
| rn_val | input | W | Second signed operand (doubled in the doubling forms) |
| res_val | output | W | Saturated signed result |
| q_set | output | 1 | Request to set the sticky overflow flag |

## Verification
The two functions that can coincide in one evaluation are the doubling clamp of `rn_val` and the final clamp of the sum or difference. When both act, a single `q_set` request must result and the output must sit at the limit chosen by the final stage. The bench provokes every such combination by sweeping all operand pairs and all four operations on 6-bit instances of both detection variants. It judges each result against an exact integer model that clamps in two stages. Directed 32-bit cases then place the double-only clamp, the final-only clamp and the joint clamp side by side at the true word limits.

// File: rtl/qarith_pkg.sv
package qarith_pkg;

   typedef enum logic [1:0] {
      QOP_ADD  = 2'b00,
      QOP_SUB  = 2'b01,
      QOP_DADD = 2'b10,
      QOP_DSUB = 2'b11
   } qop_e;

   function automatic logic op_is_doubling(input qop_e op);
      return op == QOP_DADD || op == QOP_DSUB;
   endfunction

   function automatic logic op_is_subtract(input qop_e op);
      return op == QOP_SUB || op == QOP_DSUB;
   endfunction

endpackage

// File: rtl/qarith_doubler.sv
// Saturating multiply-by-two of a signed operand.
module qarith_doubler #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         clamped
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic [W:0] twice;

   always_comb begin
      twice   = {din, 1'b0};
      // exact double fits only if the two top bits of the widened value agree
      clamped = twice[W] ^ twice[W-1];
      if (clamped)
         dout = din[W-1] ? MINV : MAXV;
      else
         dout = twice[W-1:0];
   end
endmodule

// File: rtl/qarith_addsub.sv
// Saturating signed add or subtract; DETECT_WIDE picks the overflow method.
module qarith_addsub #(
   parameter int W           = 32,
   parameter bit DETECT_WIDE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         clamped
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] raw;
   logic         ovf;
   logic         to_pos;

   generate
      if (DETECT_WIDE) begin : g_wide
         logic [W:0] ext_a, ext_b, ext_r;
         always_comb begin
            ext_a = {a[W-1], a};
            ext_b = {b[W-1], b};
            ext_r = sub ? (ext_a - ext_b) : (ext_a + ext_b);
            raw    = ext_r[W-1:0];
            ovf    = ext_r[W] ^ ext_r[W-1];
            to_pos = ~ext_r[W];
         end
      end else begin : g_sign
         logic [W-1:0] b_eff;
         always_comb begin
            b_eff  = sub ? ~b : b;
            raw    = a + b_eff + {{(W-1){1'b0}}, sub};
            ovf    = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
            to_pos = ~a[W-1];
         end
      end
   endgenerate

   always_comb begin
      clamped = ovf;
      if (ovf)
         sum = to_pos ? MAXV : MINV;
      else
         sum = raw;
   end
endmodule

// File: rtl/qarith_unit.sv
module qarith_unit
   import qarith_pkg::*;
#(
   parameter int W           = 32,
   parameter bit DETECT_WIDE = 1'b1
) (
   input  logic [1:0]   op_sel,
   input  logic [W-1:0] rm_val,
   input  logic [W-1:0] rn_val,
   output logic [W-1:0] res_val,
   output logic         q_set
);
   generate
      if (W < 2) begin : g_bad_width
         $error("qarith_unit: W must be at least 2");
      end
   endgenerate

   qop_e         op;
   logic         use_dbl;
   logic         use_sub;
   logic [W-1:0] dbl_val;
   logic         dbl_clamp;
   logic [W-1:0] b_opnd;
   logic         fin_clamp;

   always_comb begin
      op      = qop_e'(op_sel);
      use_dbl = op_is_doubling(op);
      use_sub = op_is_subtract(op);
   end

   qarith_doubler #(.W(W)) u_dbl (
      .din     (rn_val),
      .dout    (dbl_val),
      .clamped (dbl_clamp)
   );

   assign b_opnd = use_dbl ? dbl_val : rn_val;

   qarith_addsub #(.W(W), .DETECT_WIDE(DETECT_WIDE)) u_as (
      .a       (rm_val),
      .b       (b_opnd),
      .sub     (use_sub),
      .sum     (res_val),
      .clamped (fin_clamp)
   );

   assign q_set = (use_dbl & dbl_clamp) | fin_clamp;
endmodule

module qarith_unit_chk #(
   parameter int W = 32
) (
   input logic [1:0]   op_sel,
   input logic [W-1:0] rm_val,
   input logic [W-1:0] rn_val,
   input logic [W-1:0] res_val,
   input logic         q_set
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      // R1: no request means the plain wrapped sum is exact
      p_add_exact_r1: assert (!(op_sel == 2'b00 && !q_set) || res_val == W'(rm_val + rn_val))
         else $error("p_add_exact_r1");
      // R2
      p_sub_exact_r2: assert (!(op_sel == 2'b01 && !q_set) || res_val == W'(rm_val - rn_val))
         else $error("p_sub_exact_r2");
      // R3
      p_dadd_exact_r3: assert (!(op_sel == 2'b10 && !q_set) || res_val == W'(rm_val + (rn_val << 1)))
         else $error("p_dadd_exact_r3");
      // R4
      p_dsub_exact_r4: assert (!(op_sel == 2'b11 && !q_set) || res_val == W'(rm_val - (rn_val << 1)))
         else $error("p_dsub_exact_r4");
      // R5: a plain-op request always lands on a limit matching the overflow side
      p_limit_r5: assert (!(op_sel[1] == 1'b0 && q_set) || res_val == MAXV || res_val == MINV)
         else $error("p_limit_r5");
      p_add_side_r5: assert (!(op_sel == 2'b00 && q_set) || (res_val == MAXV) == (rm_val[W-1] == 1'b0))
         else $error("p_add_side_r5");
      // R6: an overflowing double always raises the request in doubling ops
      p_dbl_raises_r6: assert (!(op_sel[1] && (rn_val[W-1] != rn_val[W-2])) || q_set)
         else $error("p_dbl_raises_r6");
   end
endmodule

bind qarith_unit qarith_unit_chk #(.W(W)) u_chk (.*);

// File: tb/test_qarith_unit.sv
module test_qarith_unit;
   localparam int WB = 32;
   localparam int WS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [1:0]    op_b;
   logic [WB-1:0] rm_b, rn_b, res_b;
   logic          q_b;

   logic [1:0]    op_s;
   logic [WS-1:0] rm_s, rn_s, res_sw, res_ss;
   logic          q_sw, q_ss;

   qarith_unit #(.W(WB), .DETECT_WIDE(1'b1)) i_qarith_unit (
      .op_sel(op_b), .rm_val(rm_b), .rn_val(rn_b), .res_val(res_b), .q_set(q_b));

   qarith_unit #(.W(WS), .DETECT_WIDE(1'b1)) i_qarith_unit_sw (
      .op_sel(op_s), .rm_val(rm_s), .rn_val(rn_s), .res_val(res_sw), .q_set(q_sw));

   qarith_unit #(.W(WS), .DETECT_WIDE(1'b0)) i_qarith_unit_ss (
      .op_sel(op_s), .rm_val(rm_s), .rn_val(rn_s), .res_val(res_ss), .q_set(q_ss));

   function automatic longint sx(longint raw, int w);
      longint m = (longint'(1) << w) - 1;
      longint v = raw & m;
      return v[w-1] ? v - (longint'(1) << w) : v;
   endfunction

   function automatic longint clampv(longint v, int w, output bit hit);
      longint mx = (longint'(1) << (w-1)) - 1;
      longint mn = -mx - 1;
      hit = (v > mx) || (v < mn);
      return v > mx ? mx : (v < mn ? mn : v);
   endfunction

   // two-stage exact model
   task automatic model(input int w, input logic [1:0] op, input longint rmr, input longint rnr,
                        output longint res, output bit q);
      longint a = sx(rmr, w);
      longint n = sx(rnr, w);
      longint b, r;
      bit qd, qf;
      qd = 1'b0;
      if (op[1]) b = clampv(2 * n, w, qd);
      else b = n;
      r   = op[0] ? a - b : a + b;
      res = clampv(r, w, qf) & ((longint'(1) << w) - 1);
      q   = qd | qf;
   endtask

   task automatic chk(input string req, input int w, input logic [1:0] op,
                      input longint rmr, input longint rnr, input longint got, input bit gq);
      longint er;
      bit eq;
      model(w, op, rmr, rnr, er, eq);
      total++;
      if (got != er || gq != eq) begin
         bad++;
         $display("FAIL %s w=%0d op=%b rm=%h rn=%h: got res=%h q=%0b expected res=%h q=%0b",
                  req, w, op, rmr, rnr, got, gq, er, eq);
      end
   endtask

   function automatic string req_of(logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic run_big(input string req, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      @(posedge clk);
      op_b = op; rm_b = a; rn_b = b;
      @(negedge clk);
      chk(req, WB, op, longint'(a), longint'(b), longint'(res_b), q_b);
   endtask

   initial begin
      op_b = 2'b00; rm_b = '0; rn_b = '0;
      op_s = 2'b00; rm_s = '0; rn_s = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // idle/reset state: zero inputs give zero and no request (R1, R8)
      total++;
      if (res_b !== '0 || q_b !== 1'b0) begin
         bad++;
         $display("FAIL R1 idle: got res=%h q=%b expected res=0 q=0", res_b, q_b);
      end

      // R5 R6 R7: directed word-level corners
      run_big("R1 R5 positive clamp",   2'b00, 32'h7FFF_FFFF, 32'h0000_0001);
      run_big("R1 R5 negative clamp",   2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
      run_big("R2 R5 sub of minimum",   2'b01, 32'h0000_0000, 32'h8000_0000);
      run_big("R2 R5 negative clamp",   2'b01, 32'h8000_0000, 32'h0000_0001);
      run_big("R3 R6 double-only clamp", 2'b10, 32'hFFFF_FFFF, 32'h4000_0000);
      run_big("R3 R6 joint clamp",       2'b10, 32'h0000_0001, 32'h4000_0000);
      run_big("R4 R6 double-only clamp", 2'b11, 32'h0000_0000, 32'h4000_0000);
      run_big("R4 R6 joint clamp",       2'b11, 32'h8000_0000, 32'h4000_0000);
      run_big("R4 R5 dbl minimum",       2'b11, 32'h0000_0005, 32'h8000_0000);
      run_big("R7 plain ignores double", 2'b00, 32'hC000_0000, 32'h4000_0000);
      run_big("R7 plain sub no double",  2'b01, 32'h4000_0000, 32'h4000_0000);
      run_big("R3 in range",             2'b10, 32'h1234_5678, 32'h0000_1000);

      // exhaustive sweep on the small width, both detection variants (R1..R6)
      for (int op = 0; op < 4; op++) begin
         for (int a = 0; a < (1 << WS); a++) begin
            for (int b = 0; b < (1 << WS); b++) begin
               @(posedge clk);
               op_s = 2'(op); rm_s = WS'(a); rn_s = WS'(b);
               @(negedge clk);
               chk(req_of(2'(op)), WS, 2'(op), longint'(a), longint'(b), longint'(res_sw), q_sw);
               chk(req_of(2'(op)), WS, 2'(op), longint'(a), longint'(b), longint'(res_ss), q_ss);
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule